// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps a running calendar of seconds, minutes, hours, day of week, day of month, month and a three-digit year. A reference enable input, pulsed at 32768 Hz in a real system, is counted down by a prescaler. Each completed count advances the calendar by one second. The calendar handles the end of every minute, hour, day, month and year, and it knows the lengths of the months and the leap-year rule.

Software reaches the block through a flat register port. Writes take effect on the clock edge. Reads are combinational from the address. Time is held in binary inside the block and converted to BCD at the register boundary in both directions. The month reads and writes as 1 to 12. The year uses a hundreds digit above a two-digit BCD byte.

An alarm compares six time fields against their own compare registers. The alarm fires when any single enabled field matches, not only when all of them match. A hit sets a pending flag, and the interrupt output then stays high until software clears that flag.

Top module: `bcd_calendar`

## Requirements
- R1: While the run bit (control register, offset 0, bit 0) is 1, the calendar advances by one second on every PRESCALE-th sampled `refTick` (default 32768). A write that changes the run bit from 0 to 1 restarts this count, so the first advance comes exactly PRESCALE ticks later.
- R2: While the run bit is 0, the calendar does not advance. Writes to the time registers (offsets 9 to 15) are also ignored while the run bit is 0; the value the bit held before the write is the one that counts.
- R3: Seconds and minutes wrap from 59 to 00 and hours wrap from 23 to 00. On each day rollover the weekday (offset 12) counts 0 to 6 and then returns to 0.
- R4: The day of month wraps to 1 after the month's last day, and the month then advances. April, June, September and November have 30 days; the other months, apart from February, have 31. February has 29 days when the full year (YEAR_BASE, default 2000, plus the held year) is divisible by 4, except century years that are not divisible by 400.
- R5: The month (offset 14) reads and writes as BCD 01 to 12 and wraps from 12 to 01. The year (offset 15) is 12-bit BCD: bits 11:8 hold hundreds and bits 7:0 hold tens and units. Year 999 wraps to 000 when the month wraps.
- R6: The time registers read back in BCD at these offsets: 9 seconds, 10 minutes, 11 hours, 12 weekday, 13 day, 14 month, 15 year.
- R7: The compare registers sit at offsets 3 to 8, in the order seconds, minutes, hour, day, month, year. Writes are masked: seconds and minutes to 7 bits, hour and day to 6 bits, month to 5 bits, year to 12 bits.
- R8: The alarm enable register (offset 2) uses bits 0 to 5 as per-field compare enables, in compare-register order, and bit 6 as the global enable. One cycle after each advance, if bit 6 is set and any enabled field equals its compare value in register encoding, the pending flag (offset 1, bit 1) and `alarmIrq` go high. The weekday is never compared.
- R9: Writing 1 to offset 1 bit 1 clears the pending flag and lowers `alarmIrq`; writing 0 there has no effect. A new hit in the same cycle as a clear wins.
- R10: `alarmIrq` is a level. It stays high until it is cleared, even across later seconds with no match.
- R11: Offsets 16 and above read as zero, and writes to them change no register.
- R12: After reset the run bit, pending flag, alarm enables and compare registers are zero. The time reads 00:00:00, weekday 0, day 01, month 01, year 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refTick | input | 1 | Reference enable pulse counted by the prescaler |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register offset for read and write |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Combinational read data for regAddr |
| alarmIrq | output | 1 | Alarm interrupt level |

## Verification
Directed calendar starting points sit just before each carry boundary: end of day with weekday 6, the last day of 30- and 31-day months, February in a leap year, a plain century year and a 400-divisible year, and year 999 at 31 December. These separate a wrong month-length table or leap rule from a wrong carry chain. Random times weighted toward 59 seconds, 59 minutes, 23 hours and the last day of the month are run through several seconds each. Their compare values are chosen near the coming time and their enable masks are random, which tells any-field matching apart from all-field matching and checks that the global enable gates the flag. Directed sequences on the run bit check that counting restarts and that time writes are dropped while stopped, and clear writes with bit 1 at 0 and at 1 check that the flag is sticky.

// File: rtl/calendar_pkg.sv
package calendar_pkg;

  localparam int NUM_CMP  = 6;
  localparam int NUM_TIME = 7;

  localparam int RA_CTRL  = 0;
  localparam int RA_PEND  = 1;
  localparam int RA_ALMEN = 2;
  localparam int RA_CMP0  = 3;
  localparam int RA_TIME0 = 9;
  localparam int RA_LAST  = 15;

  typedef struct packed {
    logic                advance;
    logic [NUM_TIME-1:0] timeWr;
    logic [NUM_CMP-1:0]  cmpWr;
  } dpStrobe_t;

  function automatic logic [7:0] toBcd8(input logic [6:0] v);
    logic [6:0] tens;
    tens = v / 7'd10;
    return {tens[3:0], 4'(v - tens * 7'd10)};
  endfunction

  function automatic logic [6:0] fromBcd8(input logic [7:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [11:0] toBcd12(input logic [9:0] v);
    logic [9:0] hund;
    logic [9:0] rest;
    hund = v / 10'd100;
    rest = v - hund * 10'd100;
    return {hund[3:0], toBcd8(rest[6:0])};
  endfunction

  function automatic logic [9:0] fromBcd12(input logic [11:0] b);
    return 10'(b[11:8]) * 10'd100 + 10'(fromBcd8(b[7:0]));
  endfunction

  function automatic logic isLeap(input int fullYear);
    return (fullYear % 4 == 0) && ((fullYear % 100 != 0) || (fullYear % 400 == 0));
  endfunction

  // month index is zero-based inside the block
  function automatic logic [4:0] daysInMonth(input logic [3:0] mon0, input logic leap);
    case (mon0)
      4'd1:                    return leap ? 5'd29 : 5'd28;
      4'd3, 4'd5, 4'd8, 4'd10: return 5'd30;
      default:                 return 5'd31;
    endcase
  endfunction

  function automatic logic [11:0] cmpMask(input int idx);
    case (idx)
      0, 1:    return 12'h07F;
      2, 3:    return 12'h03F;
      4:       return 12'h01F;
      default: return 12'hFFF;
    endcase
  endfunction

  // compare index -> time register index (weekday is skipped)
  function automatic int cmpToTime(input int idx);
    return (idx < 3) ? idx : idx + 1;
  endfunction

endpackage

// File: rtl/calendar_ctrl.sv
module calendar_ctrl
  import calendar_pkg::*;
#(
  parameter int PRESCALE = 32768,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                refTick,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [NUM_CMP-1:0]  fieldMatch,
  output dpStrobe_t           stb,
  output logic [DATA_W-1:0]   ctrlRdData,
  output logic                alarmIrq
);

  localparam int CNT_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PRESCALE - 1);

  logic             runEn;
  logic [CNT_W-1:0] preCnt;
  logic [6:0]       almEn;
  logic             alarmPend;
  logic             alarmChk;

  logic wrCtrl, wrPend, wrAlmEn;
  logic advanceNow, alarmSet, alarmClr;
  logic [NUM_TIME-1:0] timeWrVec;
  logic [NUM_CMP-1:0]  cmpWrVec;

  assign wrCtrl  = regWrEn && (regAddr == ADDR_W'(RA_CTRL));
  assign wrPend  = regWrEn && (regAddr == ADDR_W'(RA_PEND));
  assign wrAlmEn = regWrEn && (regAddr == ADDR_W'(RA_ALMEN));

  assign advanceNow = runEn && refTick && (preCnt == '0);

  genvar gi;
  generate
    for (gi = 0; gi < NUM_TIME; gi++) begin : g_timeWr
      assign timeWrVec[gi] = regWrEn && runEn && (regAddr == ADDR_W'(RA_TIME0 + gi));
    end
    for (gi = 0; gi < NUM_CMP; gi++) begin : g_cmpWr
      assign cmpWrVec[gi] = regWrEn && (regAddr == ADDR_W'(RA_CMP0 + gi));
    end
  endgenerate

  assign stb = {advanceNow, timeWrVec, cmpWrVec};

  assign alarmSet = alarmChk && almEn[6] && |(almEn[5:0] & fieldMatch);
  assign alarmClr = wrPend && regWrData[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn     <= 1'b0;
      preCnt    <= '0;
      almEn     <= '0;
      alarmPend <= 1'b0;
      alarmChk  <= 1'b0;
    end else begin
      alarmChk <= advanceNow;
      if (wrCtrl) runEn <= regWrData[0];
      if (wrCtrl && regWrData[0] && !runEn) preCnt <= CNT_TOP;
      else if (advanceNow)                  preCnt <= CNT_TOP;
      else if (runEn && refTick)            preCnt <= preCnt - 1'b1;
      if (wrAlmEn) almEn <= regWrData[6:0];
      if (alarmSet)      alarmPend <= 1'b1;
      else if (alarmClr) alarmPend <= 1'b0;
    end
  end

  always_comb begin
    ctrlRdData = '0;
    if (regAddr == ADDR_W'(RA_CTRL))       ctrlRdData = DATA_W'(runEn);
    else if (regAddr == ADDR_W'(RA_PEND))  ctrlRdData = DATA_W'({alarmPend, 1'b0});
    else if (regAddr == ADDR_W'(RA_ALMEN)) ctrlRdData = DATA_W'(almEn);
  end

  assign alarmIrq = alarmPend;

endmodule

// File: rtl/calendar_datapath.sv
module calendar_datapath
  import calendar_pkg::*;
#(
  parameter int YEAR_BASE = 2000,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [NUM_CMP-1:0] fieldMatch,
  output logic [DATA_W-1:0]  dpRdData
);

  logic [5:0] secR, minR;
  logic [4:0] hourR, mdayR;
  logic [2:0] wdayR;
  logic [3:0] monR;
  logic [9:0] yearR;

  logic       leapYear;
  logic [4:0] monthDays;
  logic       secWrap, minWrap, dayTick, mdayWrap, monWrap;
  logic [6:0] byteBin;
  logic [9:0] yearIn;

  logic [11:0] timeBcd [NUM_TIME];
  logic [11:0] cmpReg  [NUM_CMP];

  always_comb begin
    leapYear  = isLeap(YEAR_BASE + int'(yearR));
    monthDays = daysInMonth(monR, leapYear);
    secWrap   = stb.advance && (secR >= 6'd59);
    minWrap   = secWrap && (minR >= 6'd59);
    dayTick   = minWrap && (hourR >= 5'd23);
    mdayWrap  = dayTick && (mdayR >= monthDays);
    monWrap   = mdayWrap && (monR >= 4'd11);
    byteBin   = fromBcd8(regWrData[7:0]);
    yearIn    = fromBcd12(regWrData[11:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secR  <= '0;
      minR  <= '0;
      hourR <= '0;
      wdayR <= '0;
      mdayR <= 5'd1;
      monR  <= '0;
      yearR <= '0;
    end else begin
      if (stb.timeWr[0])    secR <= 6'(byteBin);
      else if (stb.advance) secR <= secWrap ? 6'd0 : secR + 6'd1;

      if (stb.timeWr[1])    minR <= 6'(byteBin);
      else if (secWrap)     minR <= (minR >= 6'd59) ? 6'd0 : minR + 6'd1;

      if (stb.timeWr[2])    hourR <= 5'(byteBin);
      else if (minWrap)     hourR <= (hourR >= 5'd23) ? 5'd0 : hourR + 5'd1;

      if (stb.timeWr[3])    wdayR <= 3'(byteBin);
      else if (dayTick)     wdayR <= (wdayR >= 3'd6) ? 3'd0 : wdayR + 3'd1;

      if (stb.timeWr[4])    mdayR <= 5'(byteBin);
      else if (dayTick)     mdayR <= (mdayR >= monthDays) ? 5'd1 : mdayR + 5'd1;

      if (stb.timeWr[5])    monR <= 4'(byteBin - 7'd1);
      else if (mdayWrap)    monR <= (monR >= 4'd11) ? 4'd0 : monR + 4'd1;

      if (stb.timeWr[6])    yearR <= yearIn;
      else if (monWrap)     yearR <= (yearR >= 10'd999) ? 10'd0 : yearR + 10'd1;
    end
  end

  always_comb begin
    timeBcd[0] = 12'(toBcd8(7'(secR)));
    timeBcd[1] = 12'(toBcd8(7'(minR)));
    timeBcd[2] = 12'(toBcd8(7'(hourR)));
    timeBcd[3] = 12'(toBcd8(7'(wdayR)));
    timeBcd[4] = 12'(toBcd8(7'(mdayR)));
    timeBcd[5] = 12'(toBcd8(7'(monR) + 7'd1));
    timeBcd[6] = toBcd12(yearR);
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CMP; gi++) begin : g_cmp
      always_ff @(posedge clk) begin
        if (!rstN)               cmpReg[gi] <= '0;
        else if (stb.cmpWr[gi])  cmpReg[gi] <= regWrData[11:0] & cmpMask(gi);
      end
      assign fieldMatch[gi] = (timeBcd[cmpToTime(gi)] == cmpReg[gi]);
    end
  endgenerate

  always_comb begin
    dpRdData = '0;
    for (int i = 0; i < NUM_CMP; i++)
      if (regAddr == ADDR_W'(RA_CMP0 + i)) dpRdData = DATA_W'(cmpReg[i]);
    for (int i = 0; i < NUM_TIME; i++)
      if (regAddr == ADDR_W'(RA_TIME0 + i)) dpRdData = DATA_W'(timeBcd[i]);
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import calendar_pkg::*;
#(
  parameter int PRESCALE  = 32768,
  parameter int YEAR_BASE = 2000,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refTick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              alarmIrq
);

  dpStrobe_t          dpStb;
  logic [NUM_CMP-1:0] fieldMatch;
  logic [DATA_W-1:0]  ctrlRdData;
  logic [DATA_W-1:0]  dpRdData;

  calendar_ctrl #(
    .PRESCALE(PRESCALE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) iCtrl (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .fieldMatch(fieldMatch), .stb(dpStb),
    .ctrlRdData(ctrlRdData), .alarmIrq(alarmIrq)
  );

  calendar_datapath #(
    .YEAR_BASE(YEAR_BASE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) iData (
    .clk(clk), .rstN(rstN), .stb(dpStb),
    .regAddr(regAddr), .regWrData(regWrData),
    .fieldMatch(fieldMatch), .dpRdData(dpRdData)
  );

  assign regRdData = ctrlRdData | dpRdData;

endmodule

// File: rtl/calendar_checker.sv
module calendar_checker #(
  parameter int PRESCALE = 32768,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              refTick,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              alarmIrq,
  input logic              advance
);

  logic shadowRun;
  int   tickCnt;
  logic runWrite, clearWrite;

  assign runWrite   = regWrEn && (regAddr == ADDR_W'(0));
  assign clearWrite = regWrEn && (regAddr == ADDR_W'(1)) && regWrData[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowRun <= 1'b0;
      tickCnt   <= 0;
    end else begin
      if (runWrite) shadowRun <= regWrData[0];
      if (runWrite && regWrData[0] && !shadowRun) tickCnt <= 0;
      else if (shadowRun && refTick)              tickCnt <= advance ? 0 : tickCnt + 1;
    end
  end

  // R1: an advance closes exactly PRESCALE sampled ticks
  a_r1_tick_period: assert property (@(posedge clk) disable iff (!rstN)
    advance |-> (shadowRun && refTick && tickCnt == PRESCALE - 1));

  // R2: no advance while stopped
  a_r2_halt_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    !shadowRun |-> !advance);

  // R8: the flag rises only one cycle after an advance
  a_r8_rise_after_advance: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmIrq) |-> $past(advance, 2));

  // R9: a clear without a competing hit lowers the output
  a_r9_clear_lowers: assert property (@(posedge clk) disable iff (!rstN)
    (clearWrite && !$past(advance)) |=> !alarmIrq);

  // R10: the output is a level held until cleared
  a_r10_level_holds: assert property (@(posedge clk) disable iff (!rstN)
    (alarmIrq && !clearWrite) |=> alarmIrq);

  // R11: unmapped offsets read zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > ADDR_W'(15)) |-> (regRdData == '0));

endmodule

bind bcd_calendar calendar_checker #(
  .PRESCALE(PRESCALE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) iChecker (
  .clk(clk), .rstN(rstN), .refTick(refTick),
  .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .regRdData(regRdData), .alarmIrq(alarmIrq), .advance(dpStb.advance)
);

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;

  localparam int PRESCALE = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refTick = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        alarmIrq;

  int checks = 0;
  int fails  = 0;

  // model state: month 1..12, year 0..999
  int mS, mMi, mH, mW, mD, mMo, mY;
  int mC [6];
  int mAE;
  int mPend;

  bcd_calendar #(.PRESCALE(PRESCALE)) i_bcd_calendar (
    .clk(clk), .rstN(rstN), .refTick(refTick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .alarmIrq(alarmIrq)
  );

  always #5 clk = ~clk;

  function automatic int bcd2(int v);
    return ((v / 10) << 4) | (v % 10);
  endfunction

  function automatic int bcd3(int y);
    return ((y / 100) << 8) | bcd2(y % 100);
  endfunction

  function automatic int leapM(int y);
    int f;
    f = 2000 + y;
    return ((f % 4 == 0) && ((f % 100 != 0) || (f % 400 == 0))) ? 1 : 0;
  endfunction

  function automatic int dimM(int mo, int y);
    if (mo == 2) return leapM(y) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic int maskM(int i);
    if (i < 2) return 'h7F;
    if (i < 4) return 'h3F;
    if (i == 4) return 'h1F;
    return 'hFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 5'(a); regWrData = 16'(d);
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 1 && (d & 2) != 0) mPend = 0;
    if (a == 2) mAE = d & 'h7F;
    if (a >= 3 && a <= 8) mC[a-3] = d & maskM(a - 3);
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    regAddr = 5'(a);
    #1 v = int'(regRdData);
  endtask

  task automatic expectReg(input int a, input int exp, input string req, input string what);
    int v;
    rd(a, v);
    chk(v == exp, req, what, v, exp);
  endtask

  task automatic tickRef(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); refTick = 1'b1;
    end
    @(negedge clk); refTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic modelStep();
    int cur [6];
    mS++;
    if (mS >= 60) begin
      mS = 0; mMi++;
      if (mMi >= 60) begin
        mMi = 0; mH++;
        if (mH >= 24) begin
          mH = 0;
          mW = (mW >= 6) ? 0 : mW + 1;
          if (mD >= dimM(mMo, mY)) begin
            mD = 1;
            if (mMo >= 12) begin
              mMo = 1;
              mY = (mY >= 999) ? 0 : mY + 1;
            end else mMo++;
          end else mD++;
        end
      end
    end
    cur[0] = bcd2(mS); cur[1] = bcd2(mMi); cur[2] = bcd2(mH);
    cur[3] = bcd2(mD); cur[4] = bcd2(mMo); cur[5] = bcd3(mY);
    if ((mAE & 'h40) != 0)
      for (int i = 0; i < 6; i++)
        if (((mAE >> i) & 1) != 0 && cur[i] == mC[i]) mPend = 1;
  endtask

  task automatic advSec(input int n);
    for (int i = 0; i < n; i++) begin
      tickRef(PRESCALE);
      modelStep();
    end
  endtask

  task automatic setTime(input int s, input int mi, input int h, input int w,
                         input int d, input int mo, input int y);
    wr(9, bcd2(s));  wr(10, bcd2(mi)); wr(11, bcd2(h)); wr(12, bcd2(w));
    wr(13, bcd2(d)); wr(14, bcd2(mo)); wr(15, bcd3(y));
    mS = s; mMi = mi; mH = h; mW = w; mD = d; mMo = mo; mY = y;
  endtask

  task automatic checkTime(input string req);
    expectReg(9,  bcd2(mS),  req, "seconds");
    expectReg(10, bcd2(mMi), req, "minutes");
    expectReg(11, bcd2(mH),  req, "hours");
    expectReg(12, bcd2(mW),  req, "weekday");
    expectReg(13, bcd2(mD),  req, "day");
    expectReg(14, bcd2(mMo), req, "month");
    expectReg(15, bcd3(mY),  req, "year");
  endtask

  task automatic checkAlarm(input string req);
    int v;
    rd(1, v);
    chk(v == (mPend << 1), req, "pending", v, mPend << 1);
    chk(int'(alarmIrq) == mPend, req, "alarmIrq", int'(alarmIrq), mPend);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int v, s0, lo, span;
    void'($urandom(32'h5EED_0042));
    mS = 0; mMi = 0; mH = 0; mW = 0; mD = 1; mMo = 1; mY = 0;
    mAE = 0; mPend = 0;
    for (int i = 0; i < 6; i++) mC[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12: reset values
    expectReg(0, 0, "R12", "run bit");
    expectReg(2, 0, "R12", "alarm enables");
    for (int i = 3; i <= 8; i++) expectReg(i, 0, "R12", "compare reg");
    checkTime("R12");
    checkAlarm("R12");

    // R2: stopped clock ignores time writes and ticks
    wr(9, 'h30);
    expectReg(9, 0, "R2", "seconds write while stopped");
    tickRef(PRESCALE * 2);
    expectReg(9, 0, "R2", "no advance while stopped");

    // R1: start restarts the count
    wr(0, 1);
    tickRef(PRESCALE - 1);
    expectReg(9, 0, "R1", "seconds before full count");
    tickRef(1); modelStep();
    expectReg(9, 1, "R1", "seconds after full count");
    tickRef(3);
    wr(0, 0); wr(0, 1);
    tickRef(PRESCALE - 1);
    expectReg(9, 1, "R1", "restart holds partial count");
    tickRef(1); modelStep();
    expectReg(9, 2, "R1", "advance after restart");

    // R3: end of day, weekday wrap
    setTime(59, 59, 23, 6, 10, 5, 23);
    advSec(1);
    checkTime("R3");
    expectReg(12, 0, "R3", "weekday wraps to 0");

    // R4: month lengths and leap rule
    setTime(59, 59, 23, 2, 28, 2, 24);  advSec(1); checkTime("R4");
    expectReg(13, 'h29, "R4", "leap February 29");
    setTime(59, 59, 23, 2, 28, 2, 100); advSec(1); checkTime("R4");
    expectReg(14, 'h03, "R4", "century non-leap to March");
    setTime(59, 59, 23, 2, 29, 2, 0);   advSec(1); checkTime("R4");
    setTime(59, 59, 23, 2, 30, 4, 7);   advSec(1); checkTime("R4");
    setTime(59, 59, 23, 2, 31, 1, 7);   advSec(1); checkTime("R4");

    // R5: year rollover 999 -> 000
    setTime(59, 59, 23, 3, 31, 12, 999); advSec(1); checkTime("R5");
    expectReg(15, 0, "R5", "year wraps");
    expectReg(14, 1, "R5", "month wraps to 01");

    // R6: plain readback of a written time
    setTime(12, 34, 5, 4, 17, 9, 345);
    checkTime("R6");

    // R7: compare masks
    wr(3, 'hFF);   expectReg(3, 'h7F,  "R7", "sec compare mask");
    wr(5, 'hFF);   expectReg(5, 'h3F,  "R7", "hour compare mask");
    wr(7, 'hFF);   expectReg(7, 'h1F,  "R7", "month compare mask");
    wr(8, 'hFFFF); expectReg(8, 'hFFF, "R7", "year compare mask");

    // R8: global enable gates the flag
    setTime(10, 0, 0, 0, 1, 1, 0);
    wr(3, 'h11); wr(2, 'h01);
    advSec(1); checkAlarm("R8");
    wr(3, 'h12); wr(2, 'h41);
    advSec(1); checkAlarm("R8");
    chk(mPend == 1, "R8", "model expects hit", mPend, 1);

    // R10: level held over seconds without a hit
    advSec(3); checkAlarm("R10");

    // R9: write 0 has no effect, write 1 clears
    wr(1, 0); checkAlarm("R9");
    wr(1, 2); checkAlarm("R9");

    // R11: unmapped offsets
    wr(20, 'hFFFF);
    expectReg(20, 0, "R11", "unmapped read");
    expectReg(31, 0, "R11", "unmapped read top");
    expectReg(0, 1, "R11", "run bit untouched");
    expectReg(2, 'h41, "R11", "alarm enables untouched");

    // R8 R3 R4 R5: random stimulus near carry boundaries
    for (int it = 0; it < 40; it++) begin
      int s, mi, h, w, d, mo, y, n;
      mo = 1 + int'($urandom % 12);
      y  = int'($urandom % 1000);
      s  = ($urandom % 2) ? 57 + int'($urandom % 3) : int'($urandom % 60);
      mi = ($urandom % 2) ? 59 : int'($urandom % 60);
      h  = ($urandom % 2) ? 23 : int'($urandom % 24);
      w  = int'($urandom % 7);
      d  = ($urandom % 2) ? dimM(mo, y) : 1 + int'($urandom % dimM(mo, y));
      setTime(s, mi, h, w, d, mo, y);
      wr(3, bcd2((s + 1 + int'($urandom % 4)) % 60));
      wr(4, bcd2((mi + int'($urandom % 2)) % 60));
      wr(5, bcd2(int'($urandom % 24)));
      wr(6, bcd2(1 + int'($urandom % 3)));
      wr(7, bcd2(1 + int'($urandom % 12)));
      wr(8, bcd3(y + int'($urandom % 2)));
      wr(2, int'($urandom % 64) | (($urandom % 4 != 0) ? 'h40 : 0));
      n = 1 + int'($urandom % 4);
      advSec(n);
      checkTime("R3");
      checkAlarm("R8");
      wr(1, 2);
    end
    checkAlarm("R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule